// File: doc/BRIEF.md
# Shared-Bus Address Decoder with Optional Decode Wait State

This block is the central address decoder of a shared system bus. Each cycle it looks at the transfer type, the address and the protection level of the master that holds the bus. From these it drives one select line per slave, and it drives the three-bit transfer response that the master sees. When a slave is selected, the response is passed through from that slave unchanged. When no slave is selected, the decoder answers by itself. This happens during address-only cycles, during its own inserted decode cycles, and for accesses that miss the map or break a protection rule.

A build-time parameter picks one of two timing modes. In the decode-cycle mode, every non-sequential transfer begins with one inserted wait cycle, so the address decode gets a full cycle of its own. Sequential beats of a burst reuse the stored decode and get no extra cycle. In the direct mode, the decode and the slave's response happen in the same cycle as the address. The address map is a parameter set of base/mask windows, one window per slave. Each window has a flag that limits access to privileged masters.

Top module: `bus_sel_decoder`

## Requirements
- R1: At most one bit of `slave_sel` is high in any cycle. Slave i is selected for an address that matches window i, meaning `((addr ^ base_i) & mask_i) == 0`. When windows overlap, the lowest index wins. With the default map, 0x0xxx_xxxx selects slave 0, 0x1xxx_xxxx selects slave 1, 0x2000_xxxx selects slave 2, and any other 0x2xxx_xxxx selects slave 3.
- R2: The transfer type is encoded as 00 address-only, 01 reserved, 10 non-sequential and 11 sequential. For type 00 or 01 seen outside a transfer, no select is driven and the decoder answers DONE (000), whatever the slaves drive.
- R3: In decode-cycle mode, the first cycle of a non-sequential transfer answers WAIT (100) and drives the select of the decoded slave. From the next cycle on, the response comes from that slave and the same select stays high.
- R4: A sequential transfer (11) that follows a successful decode, with no address-only cycle or burst-break response in between, is served in its first cycle by the stored select and the slave's response, with no decode cycle.
- R5: While the response has its wait bit (bit 2) high and a select is driven, the select stays the same in the next cycle, whatever the address does.
- R6: A completing slave response with the last bit set, either LAST (010) or RETRACT (011), makes the next sequential transfer go through a fresh decode. In decode-cycle mode, that means a WAIT cycle.
- R7: An address that matches no window is answered ERROR (001) with no select. In decode-cycle mode this comes as WAIT followed by ERROR. In direct mode it comes as ERROR in the same cycle.
- R8: If the matching window is flagged privileged-only and `priv` is 0, the access is treated as unmapped (R7). With `priv` at 1, the access goes to that slave as usual.
- R9: In direct mode, a non-sequential transfer to a mapped address drives the select and passes the slave's response in the same cycle as the address.
- R10: The response is {wait, last, error}. The codes are 000 DONE, 001 ERROR, 010 LAST, 011 RETRACT, 100 WAIT and 111 RETRACT-NEXT. A selected slave's response, including RETRACT-NEXT followed by RETRACT, reaches `bus_rsp` unmodified.
- R11: `bus_rsp` carries a defined value in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_type | input | 2 | Transfer type from the granted master |
| addr | input | ADDR_W | Address from the granted master |
| priv | input | 1 | 1 when the master runs privileged |
| slv_rsp | input | NUM_SLV*3 | Responses from the slaves; slave i drives bits [3i+2:3i] |
| slave_sel | output | NUM_SLV | One-hot slave select |
| bus_rsp | output | 3 | Transfer response seen by the master |

## Verification
The assertions check four things on every cycle: the select is never more than one-hot, the select holds while a wait is pending, a decode cycle always answers WAIT and a decode miss is followed by ERROR, and a burst-break response is never followed by a reused decode. Only the bench's scenarios can show that the address map, the overlap priority and the privilege flag send each address to the right slave. The same holds for the exact cycle count of each mode and for slave responses passing through unchanged, since these need expected values worked out from chosen addresses.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  localparam int RSP_W = 3;
  typedef logic [RSP_W-1:0] rsp_t;

  // {wait, last, error}
  localparam rsp_t RSP_DONE    = 3'b000;
  localparam rsp_t RSP_ERROR   = 3'b001;
  localparam rsp_t RSP_LAST    = 3'b010;
  localparam rsp_t RSP_RETRACT = 3'b011;
  localparam rsp_t RSP_WAIT    = 3'b100;
  localparam rsp_t RSP_RETNEXT = 3'b111;

  typedef enum logic [1:0] {
    XT_IDLE = 2'b00,
    XT_RSVD = 2'b01,
    XT_NSEQ = 2'b10,
    XT_SEQ  = 2'b11
  } xfer_e;

  typedef enum logic [1:0] {
    PH_REST  = 2'b00,
    PH_DATA  = 2'b01,
    PH_FAULT = 2'b10
  } phase_e;

  function automatic logic rsp_finished(rsp_t r);
    return !r[2];
  endfunction

  function automatic logic rsp_breaks_burst(rsp_t r);
    return !r[2] && r[1];
  endfunction

  function automatic logic type_is_idle(logic [1:0] t);
    return !t[1];
  endfunction

endpackage

// File: rtl/bsd_region_match.sv
module bsd_region_match #(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 32,
  parameter logic [NUM_SLV*ADDR_W-1:0] RGN_BASE = '0,
  parameter logic [NUM_SLV*ADDR_W-1:0] RGN_MASK = '0,
  parameter logic [NUM_SLV-1:0]        RGN_PRIV = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               priv,
  output logic [NUM_SLV-1:0] pick,
  output logic               legal
);

  logic [NUM_SLV-1:0] hit;
  logic               found;

  function automatic logic window_hit(logic [ADDR_W-1:0] a,
                                      logic [ADDR_W-1:0] b,
                                      logic [ADDR_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  generate
    for (genvar i = 0; i < NUM_SLV; i++) begin : g_win
      assign hit[i] = window_hit(addr, RGN_BASE[i*ADDR_W +: ADDR_W],
                                 RGN_MASK[i*ADDR_W +: ADDR_W]);
    end
  endgenerate

  // lowest index wins on overlap
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (hit[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign legal = found && !((|(pick & RGN_PRIV)) && !priv);

endmodule

// File: rtl/bsd_rsp_mux.sv
module bsd_rsp_mux
  import bsd_pkg::*;
#(
  parameter int NUM_SLV = 4
) (
  input  logic [NUM_SLV*RSP_W-1:0] slv_rsp,
  input  logic [NUM_SLV-1:0]       route,
  output rsp_t                     rsp
);

  always_comb begin
    rsp = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (route[i]) rsp = rsp | slv_rsp[i*RSP_W +: RSP_W];
    end
  end

endmodule

// File: rtl/bsd_ctrl.sv
module bsd_ctrl
  import bsd_pkg::*;
#(
  parameter int NUM_SLV    = 4,
  parameter bit DECODE_CYC = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         xfer_type,
  input  logic [NUM_SLV-1:0] pick,
  input  logic               legal,
  input  rsp_t               slave_rsp,
  output logic [NUM_SLV-1:0] slave_sel,
  output rsp_t               bus_rsp
);

  phase_e             ph_q;
  logic [NUM_SLV-1:0] sel_q;
  logic               map_ok_q;
  logic               redo_q;

  // named events
  wire at_rest     = (ph_q == PH_REST);
  wire idle_xfer   = type_is_idle(xfer_type);
  wire reuse       = at_rest && (xfer_type == XT_SEQ) && map_ok_q && !redo_q;
  wire fresh       = at_rest && !idle_xfer && !reuse;
  wire dec_cycle   = fresh && DECODE_CYC;
  wire dec_miss    = dec_cycle && !legal;
  wire direct_hit  = fresh && !DECODE_CYC && legal;
  wire direct_miss = fresh && !DECODE_CYC && !legal;
  wire from_slave  = reuse || direct_hit || (ph_q == PH_DATA);

  always_comb begin
    slave_sel = '0;
    bus_rsp   = RSP_DONE;
    if (ph_q == PH_DATA || reuse) begin
      slave_sel = sel_q;
      bus_rsp   = slave_rsp;
    end else if (ph_q == PH_FAULT) begin
      bus_rsp = RSP_ERROR;
    end else if (dec_cycle) begin
      slave_sel = legal ? pick : '0;
      bus_rsp   = RSP_WAIT;
    end else if (direct_hit) begin
      slave_sel = pick;
      bus_rsp   = slave_rsp;
    end else if (direct_miss) begin
      bus_rsp = RSP_ERROR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_REST;
      sel_q    <= '0;
      map_ok_q <= 1'b0;
      redo_q   <= 1'b0;
    end else if (ph_q == PH_FAULT) begin
      ph_q <= PH_REST;
    end else if (ph_q == PH_DATA) begin
      if (rsp_finished(slave_rsp)) begin
        ph_q   <= PH_REST;
        redo_q <= slave_rsp[1];
      end
    end else if (idle_xfer) begin
      map_ok_q <= 1'b0;
      redo_q   <= 1'b0;
    end else if (reuse) begin
      if (!rsp_finished(slave_rsp)) ph_q   <= PH_DATA;
      else                          redo_q <= slave_rsp[1];
    end else if (dec_cycle) begin
      if (legal) begin
        sel_q    <= pick;
        map_ok_q <= 1'b1;
        redo_q   <= 1'b0;
        ph_q     <= PH_DATA;
      end else begin
        map_ok_q <= 1'b0;
        ph_q     <= PH_FAULT;
      end
    end else if (direct_hit) begin
      sel_q    <= pick;
      map_ok_q <= 1'b1;
      if (rsp_finished(slave_rsp)) begin
        redo_q <= slave_rsp[1];
      end else begin
        redo_q <= 1'b0;
        ph_q   <= PH_DATA;
      end
    end else begin
      map_ok_q <= 1'b0;
    end
  end

  // R5: select frozen while a wait is pending
  p_hold_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rsp[2] && |slave_sel) |=> slave_sel == $past(slave_sel));

  // R2: address-only outside a transfer is answered by the decoder
  p_idle_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (at_rest && idle_xfer) |-> (slave_sel == '0 && bus_rsp == RSP_DONE));

  // R3: decode cycle answers WAIT and a mapped decode is carried on
  p_dec_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_cycle |-> bus_rsp == RSP_WAIT);
  p_dec_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_cycle && legal) |=> slave_sel == $past(pick));

  // R7: a decode miss is followed by ERROR with no select
  p_miss_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss |=> (bus_rsp == RSP_ERROR && slave_sel == '0));

  // R6: a burst-break completion forbids reuse next cycle
  p_redecode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (from_slave && rsp_breaks_burst(bus_rsp)) |=> !reuse);

endmodule

// File: rtl/bus_sel_decoder.sv
module bus_sel_decoder
  import bsd_pkg::*;
#(
  parameter int NUM_SLV    = 4,
  parameter int ADDR_W     = 32,
  parameter bit DECODE_CYC = 1'b1,
  parameter logic [NUM_SLV*ADDR_W-1:0] RGN_BASE =
    {32'h2000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NUM_SLV*ADDR_W-1:0] RGN_MASK =
    {32'hF000_0000, 32'hFFFF_0000, 32'hF000_0000, 32'hF000_0000},
  parameter logic [NUM_SLV-1:0] RGN_PRIV = 4'b0010
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               xfer_type,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     priv,
  input  logic [NUM_SLV*RSP_W-1:0] slv_rsp,
  output logic [NUM_SLV-1:0]       slave_sel,
  output logic [RSP_W-1:0]         bus_rsp
);

  logic [NUM_SLV-1:0] pick;
  logic               legal;
  rsp_t               slave_rsp;
  rsp_t               rsp_int;

  bsd_region_match #(
    .NUM_SLV (NUM_SLV),
    .ADDR_W  (ADDR_W),
    .RGN_BASE(RGN_BASE),
    .RGN_MASK(RGN_MASK),
    .RGN_PRIV(RGN_PRIV)
  ) u_map (
    .addr (addr),
    .priv (priv),
    .pick (pick),
    .legal(legal)
  );

  bsd_rsp_mux #(.NUM_SLV(NUM_SLV)) u_mux (
    .slv_rsp(slv_rsp),
    .route  (slave_sel),
    .rsp    (slave_rsp)
  );

  bsd_ctrl #(.NUM_SLV(NUM_SLV), .DECODE_CYC(DECODE_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_type(xfer_type),
    .pick     (pick),
    .legal    (legal),
    .slave_rsp(slave_rsp),
    .slave_sel(slave_sel),
    .bus_rsp  (rsp_int)
  );

  assign bus_rsp = rsp_int;

  // R1: select is never more than one-hot, priority pick likewise
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slave_sel));
  p_pick_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

  // R11: response defined every cycle
  p_rsp_known_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(bus_rsp));

endmodule

// File: tb/sim_bus_sel_decoder.sv
`timescale 1ns/1ps
module sim_bus_sel_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  xfer_type = 2'b00;
  logic [31:0] addr = 32'h0;
  logic        priv = 1'b0;
  logic [11:0] slv_rsp = 12'h0;
  logic [3:0]  sel0, sel1;
  logic [2:0]  rsp0, rsp1;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  bus_sel_decoder #(.DECODE_CYC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .xfer_type(xfer_type), .addr(addr),
    .priv(priv), .slv_rsp(slv_rsp), .slave_sel(sel0), .bus_rsp(rsp0));

  bus_sel_decoder #(.DECODE_CYC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .xfer_type(xfer_type), .addr(addr),
    .priv(priv), .slv_rsp(slv_rsp), .slave_sel(sel1), .bus_rsp(rsp1));

  // independent restatement of the default map
  function automatic logic [3:0] exp_slave(logic [31:0] a, logic p);
    case (a[31:28])
      4'h0: return 4'b0001;
      4'h1: return p ? 4'b0010 : 4'b0000;
      4'h2: return (a[27:16] == 12'h000) ? 4'b0100 : 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input string tag, input bit which,
                     input logic [3:0] sel_e, input logic [2:0] rsp_e);
    logic [3:0] s;
    logic [2:0] r;
    s = which ? sel1 : sel0;
    r = which ? rsp1 : rsp0;
    vectors++;
    if (s !== sel_e || r !== rsp_e) begin
      fails++;
      $display("FAIL %s u%0d: sel=%b exp %b rsp=%b exp %b",
               tag, which, s, sel_e, r, rsp_e);
    end
  endtask

  task automatic drive(input logic [1:0] t, input logic [31:0] a,
                       input logic p, input logic [11:0] sr);
    xfer_type = t;
    addr      = a;
    priv      = p;
    slv_rsp   = sr;
    @(negedge clk);
  endtask

  task automatic next_cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    drive(2'b00, 32'h0, 1'b0, 12'h0); next_cyc();
    drive(2'b00, 32'h0, 1'b0, 12'h0); next_cyc();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R2 reset idle", 0, 4'b0000, 3'b000);
    chk("R2 reset idle", 1, 4'b0000, 3'b000);
    rst_n = 1'b1;
    next_cyc();
    for (int k = 0; k < 3; k++) begin
      drive(2'b00, 32'h0, 1'b0, 12'h0);
      vectors++;
      if ($isunknown(rsp0) || $isunknown(rsp1)) begin
        fails++;
        $display("FAIL R11 rsp unknown: %b %b exp defined", rsp0, rsp1);
      end
      next_cyc();
    end
  endtask

  // slaves: {s3,s2,s1,s0}; s0 DONE, others ERROR to show routing
  task automatic t_nseq_decode();
    drive(2'b10, 32'h0000_1000, 1'b0, {3'b001, 3'b001, 3'b001, 3'b000});
    chk("R3 decode cycle", 0, exp_slave(32'h0000_1000, 1'b0), 3'b100);
    next_cyc();
    drive(2'b10, 32'h0000_1000, 1'b0, {3'b001, 3'b001, 3'b001, 3'b000});
    chk("R3 slave data", 0, 4'b0001, 3'b000);
    next_cyc();
    drive(2'b11, 32'h0000_1004, 1'b0, {3'b001, 3'b001, 3'b001, 3'b000});
    chk("R4 seq reuse", 0, 4'b0001, 3'b000);
    next_cyc();
    drive(2'b11, 32'h0000_1008, 1'b0, {3'b001, 3'b001, 3'b001, 3'b010});
    chk("R10 LAST passed", 0, 4'b0001, 3'b010);
    next_cyc();
    drive(2'b11, 32'h0000_100C, 1'b0, {3'b001, 3'b001, 3'b001, 3'b000});
    chk("R6 redecode after LAST", 0, 4'b0001, 3'b100);
    next_cyc();
    drive(2'b11, 32'h0000_100C, 1'b0, {3'b001, 3'b001, 3'b001, 3'b000});
    chk("R6 data after redecode", 0, 4'b0001, 3'b000);
    next_cyc();
    settle();
  endtask

  task automatic t_wait_hold();
    drive(2'b10, 32'h2000_0010, 1'b0, {3'b000, 3'b100, 3'b000, 3'b000});
    chk("R3 decode slave2", 0, 4'b0100, 3'b100);
    next_cyc();
    drive(2'b10, 32'h2000_0010, 1'b0, {3'b000, 3'b100, 3'b000, 3'b000});
    chk("R5 slave wait", 0, 4'b0100, 3'b100);
    next_cyc();
    drive(2'b10, 32'h0000_0000, 1'b0, {3'b000, 3'b100, 3'b000, 3'b000});
    chk("R5 hold despite addr", 0, 4'b0100, 3'b100);
    next_cyc();
    drive(2'b10, 32'h0000_0000, 1'b0, {3'b000, 3'b000, 3'b000, 3'b000});
    chk("R5 finish on slave2", 0, 4'b0100, 3'b000);
    next_cyc();
    settle();
  endtask

  task automatic t_overlap();
    drive(2'b10, 32'h2001_0000, 1'b0, 12'h0);
    chk("R1 overlap to slave3", 0, exp_slave(32'h2001_0000, 1'b0), 3'b100);
    next_cyc();
    drive(2'b10, 32'h2001_0000, 1'b0, 12'h0);
    chk("R1 slave3 data", 0, 4'b1000, 3'b000);
    next_cyc();
    settle();
  endtask

  task automatic t_fault();
    drive(2'b10, 32'h8000_0000, 1'b0, {3'b100, 3'b100, 3'b100, 3'b100});
    chk("R7 unmapped decode", 0, 4'b0000, 3'b100);
    next_cyc();
    drive(2'b10, 32'h8000_0000, 1'b0, {3'b100, 3'b100, 3'b100, 3'b100});
    chk("R7 unmapped error", 0, 4'b0000, 3'b001);
    next_cyc();
    drive(2'b00, 32'h8000_0000, 1'b0, 12'h0);
    chk("R2 idle after fault", 0, 4'b0000, 3'b000);
    next_cyc();
    drive(2'b10, 32'h1000_0040, 1'b0, 12'h0);
    chk("R8 protected decode", 0, 4'b0000, 3'b100);
    next_cyc();
    drive(2'b10, 32'h1000_0040, 1'b0, 12'h0);
    chk("R8 protected error", 0, 4'b0000, 3'b001);
    next_cyc();
    drive(2'b00, 32'h0, 1'b0, 12'h0);
    next_cyc();
    drive(2'b10, 32'h1000_0040, 1'b1, 12'h0);
    chk("R8 privileged decode", 0, exp_slave(32'h1000_0040, 1'b1), 3'b100);
    next_cyc();
    drive(2'b10, 32'h1000_0040, 1'b1, 12'h0);
    chk("R8 privileged data", 0, 4'b0010, 3'b000);
    next_cyc();
    settle();
  endtask

  task automatic t_addr_only();
    drive(2'b00, 32'h0000_0000, 1'b1, {3'b100, 3'b100, 3'b100, 3'b100});
    chk("R2 type00", 0, 4'b0000, 3'b000);
    chk("R2 type00", 1, 4'b0000, 3'b000);
    next_cyc();
    drive(2'b01, 32'h2000_0000, 1'b1, {3'b100, 3'b100, 3'b100, 3'b100});
    chk("R2 type01 reserved", 0, 4'b0000, 3'b000);
    chk("R2 type01 reserved", 1, 4'b0000, 3'b000);
    next_cyc();
    settle();
  endtask

  task automatic t_retract();
    drive(2'b10, 32'h0000_2000, 1'b0, 12'h0);
    chk("R3 decode before retract", 0, 4'b0001, 3'b100);
    next_cyc();
    drive(2'b10, 32'h0000_2000, 1'b0, {9'h0, 3'b111});
    chk("R10 RETRACT-NEXT passed", 0, 4'b0001, 3'b111);
    next_cyc();
    drive(2'b10, 32'h0000_2000, 1'b0, {9'h0, 3'b011});
    chk("R10 RETRACT passed", 0, 4'b0001, 3'b011);
    next_cyc();
    drive(2'b11, 32'h0000_2004, 1'b0, 12'h0);
    chk("R6 redecode after retract", 0, 4'b0001, 3'b100);
    next_cyc();
    drive(2'b11, 32'h0000_2004, 1'b0, 12'h0);
    chk("R6 data after retract", 0, 4'b0001, 3'b000);
    next_cyc();
    settle();
  endtask

  task automatic t_direct();
    drive(2'b10, 32'h2000_0004, 1'b0, {3'b001, 3'b000, 3'b001, 3'b001});
    chk("R9 same-cycle select", 1, exp_slave(32'h2000_0004, 1'b0), 3'b000);
    next_cyc();
    drive(2'b11, 32'h2000_0008, 1'b0, {3'b001, 3'b010, 3'b001, 3'b001});
    chk("R4 direct seq reuse", 1, 4'b0100, 3'b010);
    next_cyc();
    drive(2'b10, 32'h9000_0000, 1'b0, 12'h0);
    chk("R7 direct unmapped", 1, 4'b0000, 3'b001);
    next_cyc();
    drive(2'b10, 32'h1000_0000, 1'b0, 12'h0);
    chk("R8 direct protected", 1, 4'b0000, 3'b001);
    next_cyc();
    drive(2'b10, 32'h2000_FFFC, 1'b0, 12'h0);
    chk("R1 direct slave2 edge", 1, 4'b0100, 3'b000);
    next_cyc();
    settle();
  endtask

  initial begin
    t_reset();
    settle();
    t_nseq_decode();
    t_wait_hold();
    t_overlap();
    t_fault();
    t_addr_only();
    t_retract();
    t_direct();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule